// File: doc/BRIEF.md
# Debug-Entry Reset Sequencer for a Scan Chain

This block puts every core on a serial scan chain into reset and brings it out of reset already halted in debug mode. A host gives a single start pulse and takes no further part. The block pulls the active-low target reset low and keeps it there. While that reset is held it pulses the active-low test-reset line and then walks the test access port into the instruction shift state. It then shifts a copy of the debug-request opcode into the instruction register of every device on the chain and returns the port to Run-Test/Idle. Only then does it let target reset go, so no core runs an instruction before it halts.

The test clock comes from a divider of the system clock. TMS and TDI change only on a falling edge of the test clock, so the targets can sample them on the rising edge. The number of devices, the instruction width, the opcode, the divider and the minimum hold time are all parameters. The block shows busy for the whole sequence and gives a one-cycle done pulse when it ends.

Top module: `jtag_dbg_reset_seq`

## Requirements
- R1: In the cycle after `start` is sampled high while idle, `busy` is 1 and `tgt_rst_n` is 0.
- R2: `trst_n` goes low only while `tgt_rst_n` is low. Before `trst_n` falls there are exactly HOLD rising TCK edges with target reset held. `trst_n` stays low for exactly HOLD rising TCK edges.
- R3: After `trst_n` rises, TMS on the rising TCK edges reads HOLD ones and then 0,1,1,0,0. This is Test-Logic-Reset, then Run-Test/Idle, then on to Shift-IR.
- R4: In Shift-IR the block shifts NUM_DEV*IR_W bits. Bit k on TDI is OPCODE[k mod IR_W], so each copy goes out least significant bit first. TMS is 0 until the last bit, is 1 on the last bit, and is then followed by 1,0. At the end every device's updated instruction register holds OPCODE and the port is in Run-Test/Idle.
- R5: `tgt_rst_n` rises only in the same cycle as `done`, after Update-IR has been passed with target reset still low.
- R6: TCK has a period of 2*DIV system clocks while busy and is low while idle. TMS and TDI change only in the cycle in which TCK falls.
- R7: `busy` stays high from start to end, and `done` is high for exactly one cycle. The done pulse comes 2*DIV*(3*HOLD+7+NUM_DEV*IR_W) cycles after the start edge.
- R8: A `start` that arrives while busy is ignored. The sequence keeps its length and gives one done.
- R9: After reset and while idle the outputs are `tgt_rst_n`=1, `trst_n`=1, `tck`=0, `tms`=1, `tdi`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| start | input | 1 | Request for one reset-into-debug sequence |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when the sequence ends |
| tgt_rst_n | output | 1 | Active-low reset to all target cores |
| trst_n | output | 1 | Active-low test-logic reset to the chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial instruction data into the first device |

## Verification
The assertions assume that `start` is synchronous to `clk` and that `rst_n` is applied once before any sequence. They make no assumption about when `start` arrives. The bench drives `start` only on falling system-clock edges and holds it for whole cycles. It also drives a second `start` in the middle of a run to exercise R8. The chain is modelled in the bench as a full port state machine with one shifting instruction register per device, so the opcode placement is checked against the behaviour a real chain would show.

// File: rtl/jtag_dbg_reset_seq.sv
module jtag_dbg_reset_seq #(
  parameter int NUM_DEV = 3,
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OPCODE = 4'b0011,
  parameter int DIV = 2,
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic tgt_rst_n,
  output logic trst_n,
  output logic tck,
  output logic tms,
  output logic tdi
);
  localparam int TOT = NUM_DEV * IR_W;
  localparam int MAXC = (TOT > HOLD) ? ((TOT > 5) ? TOT : 5) : ((HOLD > 5) ? HOLD : 5);
  localparam int BW = $clog2(MAXC + 1);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [4:0] NAV = 5'b00110;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_TRST, S_TLR, S_NAV, S_SHIFT, S_EXIT} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt;
  logic [TOT-1:0] sh;

  wire last_hold = (int'(bcnt) == HOLD - 1);
  wire last_bit = (int'(bcnt) == TOT - 1);
  wire next_last = (int'(bcnt) == TOT - 2);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bcnt <= '0;
      sh <= '0;
      tck <= 1'b0;
      tms <= 1'b1;
      tdi <= 1'b0;
      tgt_rst_n <= 1'b1;
      trst_n <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0;
        tck <= 1'b0;
        if (start) begin
          st <= S_RST;
          tgt_rst_n <= 1'b0;
          bcnt <= '0;
          sh <= {NUM_DEV{OPCODE}};
        end
      end else if (int'(cnt) != DIV - 1) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        tck <= ~tck;
        if (tck) begin
          bcnt <= bcnt + 1'b1;
          case (st)
            S_RST: if (last_hold) begin
              st <= S_TRST;
              trst_n <= 1'b0;
              bcnt <= '0;
            end
            S_TRST: if (last_hold) begin
              st <= S_TLR;
              trst_n <= 1'b1;
              bcnt <= '0;
            end
            S_TLR: if (last_hold) begin
              st <= S_NAV;
              tms <= NAV[0];
              bcnt <= '0;
            end
            S_NAV: if (bcnt[2:0] == 3'd4) begin
              st <= S_SHIFT;
              bcnt <= '0;
              tms <= (TOT == 1);
              tdi <= sh[0];
              sh <= sh >> 1;
            end else begin
              tms <= NAV[bcnt[2:0] + 3'd1];
            end
            S_SHIFT: if (last_bit) begin
              st <= S_EXIT;
              bcnt <= '0;
              tms <= 1'b1;
              tdi <= 1'b0;
            end else begin
              tdi <= sh[0];
              sh <= sh >> 1;
              tms <= next_last;
            end
            S_EXIT: if (bcnt == '0) begin
              tms <= 1'b0;
            end else begin
              st <= S_IDLE;
              tgt_rst_n <= 1'b1;
              tms <= 1'b1;
              done <= 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/jtag_dbg_reset_seq_chk.sv
module jtag_dbg_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic tgt_rst_n,
  input logic trst_n,
  input logic tck,
  input logic tms,
  input logic tdi
);
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !tgt_rst_n)); // R1
  AST_TRST_INSIDE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n |-> !tgt_rst_n); // R2
  AST_BUSY_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tgt_rst_n); // R5
  AST_RELEASE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst_n) |-> done); // R5
  AST_PINS_STABLE_TCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (trst_n && tgt_rst_n && !tck)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

bind jtag_dbg_reset_seq jtag_dbg_reset_seq_chk u_chk (.*);

// File: tb/test_jtag_dbg_reset_seq.sv
`timescale 1ns/1ps
module test_jtag_dbg_reset_seq;
  localparam int NUM_DEV = 3;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OPCODE = 4'b0011;
  localparam int DIV = 2;
  localparam int HOLD = 3;
  localparam int TOT = NUM_DEV * IR_W;
  localparam int NLOG = HOLD + 7 + TOT;
  localparam int EXP_CYC = 2 * DIV * (3 * HOLD + 7 + TOT) + 1;

  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, tgt_rst_n, trst_n, tck, tms, tdi;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  jtag_dbg_reset_seq #(.NUM_DEV(NUM_DEV), .IR_W(IR_W), .OPCODE(OPCODE), .DIV(DIV), .HOLD(HOLD))
    i_jtag_dbg_reset_seq (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .tgt_rst_n(tgt_rst_n), .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi));

  function automatic int tap_next(int s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR: return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR : PDR;
      PDR: return m ? E2DR : PDR;
      E2DR: return m ? UDR : SHDR;
      UDR: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR: return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR : PIR;
      PIR: return m ? E2IR : PIR;
      E2IR: return m ? UIR : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  int tap = TLR;
  logic [IR_W-1:0] ir [NUM_DEV];
  logic [IR_W-1:0] upd [NUM_DEV];
  logic tms_log [NLOG];
  logic tdi_log [TOT];
  int nlog, nsh, pre_edges, trst_edges, bad_order, upd_open, ndone, bad_period, bad_edge, gap;
  bit seen_trst, rise_valid;
  logic ptck = 0, ptms = 1, ptdi = 0;

  task automatic clear_run();
    nlog = 0; nsh = 0; pre_edges = 0; trst_edges = 0; bad_order = 0; upd_open = 0;
    ndone = 0; bad_period = 0; bad_edge = 0; seen_trst = 0; rise_valid = 0; gap = 0;
  endtask

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tap = TLR;
      for (int i = 0; i < NUM_DEV; i++) begin ir[i] = '0; upd[i] = '0; end
      seen_trst = 1;
      if (tgt_rst_n !== 1'b0) bad_order++;
    end else begin
      int nx;
      nx = tap_next(tap, tms);
      if (tgt_rst_n === 1'b0 && !seen_trst) pre_edges++;
      if (seen_trst && tgt_rst_n === 1'b0 && nlog < NLOG) begin
        tms_log[nlog] = tms; nlog++;
      end
      if (tap == SHIR) begin
        logic cin, nin;
        cin = tdi;
        if (nsh < TOT) tdi_log[nsh] = tdi;
        nsh++;
        for (int i = 0; i < NUM_DEV; i++) begin
          nin = ir[i][0];
          ir[i] = {cin, ir[i][IR_W-1:1]};
          cin = nin;
        end
      end
      if (nx == UIR) begin
        for (int i = 0; i < NUM_DEV; i++) upd[i] = ir[i];
        if (tgt_rst_n === 1'b0) upd_open++;
      end
      tap = nx;
    end
  end

  always @(posedge tck) if (!trst_n) trst_edges++;

  always @(negedge clk) begin
    if (done) ndone++;
    if ((tms !== ptms || tdi !== ptdi) && !(ptck && !tck)) bad_edge++;
    if (busy) begin
      gap++;
      if (tck && !ptck) begin
        if (rise_valid && gap != 2 * DIV) bad_period++;
        rise_valid = 1; gap = 0;
      end
    end else if (tck) bad_period++;
    ptck = tck; ptms = tms; ptdi = tdi;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input bit poke);
    int n;
    bit ok;
    clear_run();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy === 1'b1 && tgt_rst_n === 1'b0, "R1", "busy/tgt_rst_n after start", {busy, tgt_rst_n}, 2);
    n = 1;
    while (done !== 1'b1 && n < 100000) begin
      @(negedge clk);
      n++;
      if (poke) begin
        if (n == 40) start = 1;
        if (n == 41) start = 0;
      end
      if (!done && busy !== 1'b1) begin
        chk(0, "R7", "busy dropped early", n, EXP_CYC);
        break;
      end
    end
    chk(n == EXP_CYC, poke ? "R8" : "R7", "cycles start to done", n, EXP_CYC);
    chk(tgt_rst_n === 1'b1 && busy === 1'b0, "R5", "release with done", tgt_rst_n, 1);
    chk(upd_open == 1, "R5", "Update-IR passes under held reset", upd_open, 1);
    chk(bad_order == 0, "R2", "trst_n low outside target reset", bad_order, 0);
    chk(pre_edges == HOLD, "R2", "target reset hold before trst", pre_edges, HOLD);
    chk(trst_edges == HOLD, "R2", "trst_n low width", trst_edges, HOLD);
    chk(nlog == NLOG, "R3", "TMS edges after trst release", nlog, NLOG);
    ok = 1;
    for (int k = 0; k < NLOG; k++) begin
      logic e;
      if (k < HOLD) e = 1;
      else if (k < HOLD + 5) e = (k == HOLD + 1 || k == HOLD + 2);
      else if (k < HOLD + 5 + TOT - 1) e = 0;
      else if (k < HOLD + 5 + TOT + 1) e = 1;
      else e = 0;
      if (tms_log[k] !== e) ok = 0;
    end
    chk(ok, "R3", "TMS pattern navigation and exit", ok, 1);
    chk(nsh == TOT, "R4", "bits shifted in Shift-IR", nsh, TOT);
    ok = 1;
    for (int k = 0; k < TOT; k++) if (tdi_log[k] !== OPCODE[k % IR_W]) ok = 0;
    chk(ok, "R4", "TDI bit order", ok, 1);
    for (int i = 0; i < NUM_DEV; i++)
      chk(upd[i] === OPCODE, "R4", $sformatf("IR of device %0d", i), upd[i], OPCODE);
    chk(tap == RTI, "R4", "port state at end", tap, RTI);
    chk(bad_period == 0, "R6", "TCK period errors", bad_period, 0);
    chk(bad_edge == 0, "R6", "TMS/TDI change away from TCK fall", bad_edge, 0);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done width", done, 0);
    chk(ndone == 1, poke ? "R8" : "R7", "done pulses in run", ndone, 1);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && tgt_rst_n === 1'b1 && trst_n === 1'b1 && tck === 1'b0,
        "R9", "idle after sequence", {busy, tgt_rst_n, trst_n, tck}, 6);
  endtask

  initial begin
    clear_run();
    repeat (3) @(negedge clk);
    chk(tgt_rst_n === 1 && trst_n === 1 && tck === 0 && tms === 1 && tdi === 0 && busy === 0 && done === 0,
        "R9", "outputs in reset", {tgt_rst_n, trst_n, tck, tms, tdi, busy, done}, 7'b1101000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy === 0 && tgt_rst_n === 1 && tms === 1, "R9", "idle after reset", {busy, tgt_rst_n, tms}, 3'b011);
    run_seq(0);
    run_seq(1);
    run_seq(0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not end actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule